// File: doc/BRIEF.md
# Smart Card Contact Activation Sequencer

This block is the control state machine between a host microcontroller and a smart card socket. After reset it waits in an idle state with every card contact disabled and the host data path high impedance. When the host pulls its active-low start request while the host I/O level is high, a card is present, the supply-ready qualifier is up and no supply fault is flagged, the block powers the card contacts in a fixed order. It times each step with a counter of system clock cycles. The step intervals are given in microseconds and scaled by a cycles-per-microsecond parameter.

With the contacts fully powered, the session sits in a read or a write mode that a host direction input chooses, and the host data-path enables follow that mode. The block powers the contacts down in reverse order, one interval per step, in three cases: the host releases its start request, the card is pulled out, or either supply reports a fault. It then returns to idle, or to a fault state when the fault is still present. A registered alarm output and a registered card-present status output complete the host side.

Top module: `card_seq_top`

## Requirements
- R1: While reset is held and right after it, stateCode is 0 and every contact enable and data-path enable is low, alarm is high and cardSeen is low. The stateCode encoding is 0 idle, 1 activation, 2 read, 3 write, 4 deactivation, 5 fault.
- R2: A start is accepted only in idle, and only when startN is low, ioHostHigh is high, cardPresent is high, supplyReady is high and neither fault input is high. If any of these conditions fails, the block stays in idle. vccEn rises at the clock edge that accepts the start.
- R3: Measured from the edge that accepts the start, ioEn rises after 32 µs, vppEn after 64 µs, clkEn after 192 µs and rstRelease after 256 µs. The 128 µs step changes no output. The durations are in clock cycles of CYC_PER_US per µs.
- R4: At the edge that raises rstRelease, the block enters read (dirWrite low, ioRdEn high) or write (dirWrite high, ioWrEn high). A change of dirWrite during a session takes effect at the next edge.
- R5: A high startN during read or write starts deactivation. rstRelease falls at the first edge. clkEn, vppEn, ioEn and vccEn then fall in that order, DEACT_US µs apart. The block reaches idle DEACT_US µs after vccEn falls.
- R6: A low cardPresent during activation, read or write starts the same deactivation. A start request held low during deactivation has no effect until idle is reached.
- R7: A high mainFault or hostFault during activation, read or write starts deactivation. The block ends deactivation in fault (5) if the fault is still high, and leaves fault for idle one edge after both faults clear. A fault seen in idle moves the block to fault directly.
- R8: alarm is high one edge after hostFault is high or supplyReady is low, and low otherwise. cardSeen copies cardPresent one edge late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startN | input | 1 | Active-low session request from the host |
| cardPresent | input | 1 | High when a card sits in the socket |
| ioHostHigh | input | 1 | High when the host I/O line is not low |
| dirWrite | input | 1 | Session direction: 1 write, 0 read |
| mainFault | input | 1 | Main supply fault flag |
| hostFault | input | 1 | Host logic supply fault flag |
| supplyReady | input | 1 | Supply-ready qualifier; start is blocked while low |
| vccEn | output | 1 | Card supply enable |
| ioEn | output | 1 | Card I/O contact enable |
| vppEn | output | 1 | Card programming supply enable |
| clkEn | output | 1 | Card clock enable |
| rstRelease | output | 1 | Card reset line released when high |
| ioRdEn | output | 1 | Card-to-host data path enable (read mode) |
| ioWrEn | output | 1 | Host-to-card data path enable (write mode) |
| cardSeen | output | 1 | Registered card-present status |
| alarm | output | 1 | Registered supply alarm |
| stateCode | output | 3 | Current mode, encoded as in R1 |

## Verification
The assertions assume that the supply and card inputs change only between clock edges and are held stable for at least one edge. The one-cycle fault and card-removal properties rely on this. The contact-ordering property assumes reset starts with every contact off, so the enables can only climb up or fall down the chain. The stimulus drives every input on the falling edge, holds each value for a whole table row, and never toggles a fault and the card input in the same row. Each input pattern therefore has a single meaning at the edge that samples it.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ACT   = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_DEACT = 3'd4,
    ST_FAULT = 3'd5
  } seqState_e;

  typedef enum logic [1:0] {
    TS_SHORT = 2'd0,
    TS_LONG  = 2'd1,
    TS_DEACT = 2'd2
  } timerSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      load;
    timerSel_e sel;
    logic      actStep;
    logic      deactStep;
    logic [2:0] stepIdx;
  } seqStrobe_t;

  localparam int ACT_LAST   = 5;
  localparam int DEACT_LAST = 4;

endpackage

// File: rtl/card_seq_ctrl.sv
module card_seq_ctrl
  import card_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startN,
  input  logic       cardPresent,
  input  logic       ioHostHigh,
  input  logic       dirWrite,
  input  logic       anyFault,
  input  logic       supplyReady,
  input  logic       timerDone,
  output seqState_e  state,
  output seqStrobe_t strb
);

  seqState_e stateNext;
  logic [2:0] step, stepNext;
  logic startOk, abortReq;

  assign startOk  = !startN && ioHostHigh && cardPresent && supplyReady && !anyFault;
  assign abortReq = anyFault || !cardPresent;

  always_comb begin
    stateNext = state;
    stepNext  = step;
    strb      = '0;
    strb.sel  = TS_SHORT;
    unique case (state)
      ST_IDLE: begin
        if (anyFault) begin
          stateNext = ST_FAULT;
        end else if (startOk) begin
          stateNext    = ST_ACT;
          stepNext     = 3'd0;
          strb.actStep = 1'b1;
          strb.stepIdx = 3'd0;
          strb.load    = 1'b1;
          strb.sel     = TS_SHORT;
        end
      end
      ST_ACT, ST_READ, ST_WRITE: begin
        if (abortReq || (state != ST_ACT && startN)) begin
          stateNext      = ST_DEACT;
          stepNext       = 3'd0;
          strb.deactStep = 1'b1;
          strb.stepIdx   = 3'd0;
          strb.load      = 1'b1;
          strb.sel       = TS_DEACT;
        end else if (state != ST_ACT) begin
          stateNext = dirWrite ? ST_WRITE : ST_READ;
        end else if (timerDone) begin
          strb.actStep = 1'b1;
          strb.stepIdx = step + 3'd1;
          if (step == 3'(ACT_LAST - 1)) begin
            stateNext = dirWrite ? ST_WRITE : ST_READ;
          end else begin
            stepNext  = step + 3'd1;
            strb.load = 1'b1;
            strb.sel  = (step == 3'd0) ? TS_SHORT : TS_LONG;
          end
        end
      end
      ST_DEACT: begin
        if (timerDone) begin
          if (step == 3'(DEACT_LAST)) begin
            stateNext = anyFault ? ST_FAULT : ST_IDLE;
          end else begin
            stepNext       = step + 3'd1;
            strb.deactStep = 1'b1;
            strb.stepIdx   = step + 3'd1;
            strb.load      = 1'b1;
            strb.sel       = TS_DEACT;
          end
        end
      end
      ST_FAULT: begin
        if (!anyFault) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      step  <= 3'd0;
    end else begin
      state <= stateNext;
      step  <= stepNext;
    end
  end

endmodule

// File: rtl/card_seq_dp.sv
module card_seq_dp
  import card_seq_pkg::*;
#(
  parameter int SHORT_CYC = 32,
  parameter int LONG_CYC  = 64,
  parameter int DEACT_CYC = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strb,
  input  logic       cardPresent,
  input  logic       hostFault,
  input  logic       supplyReady,
  output logic       timerDone,
  output logic       vccEn,
  output logic       ioEn,
  output logic       vppEn,
  output logic       clkEn,
  output logic       rstRelease,
  output logic       cardSeen,
  output logic       alarm
);

  localparam int MAX_A = (SHORT_CYC > LONG_CYC) ? SHORT_CYC : LONG_CYC;
  localparam int MAX_C = (MAX_A > DEACT_CYC) ? MAX_A : DEACT_CYC;
  localparam int TW    = $clog2(MAX_C + 1);

  logic [TW-1:0] timer, loadVal;

  always_comb begin
    unique case (strb.sel)
      TS_LONG:  loadVal = TW'(LONG_CYC - 1);
      TS_DEACT: loadVal = TW'(DEACT_CYC - 1);
      default:  loadVal = TW'(SHORT_CYC - 1);
    endcase
  end

  assign timerDone = (timer == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (strb.load) begin
      timer <= loadVal;
    end else if (!timerDone) begin
      timer <= timer - TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vccEn      <= 1'b0;
      ioEn       <= 1'b0;
      vppEn      <= 1'b0;
      clkEn      <= 1'b0;
      rstRelease <= 1'b0;
    end else if (strb.actStep) begin
      case (strb.stepIdx)
        3'd0: vccEn      <= 1'b1;
        3'd1: ioEn       <= 1'b1;
        3'd2: vppEn      <= 1'b1;
        3'd4: clkEn      <= 1'b1;
        3'd5: rstRelease <= 1'b1;
        default: ;
      endcase
    end else if (strb.deactStep) begin
      case (strb.stepIdx)
        3'd0: rstRelease <= 1'b0;
        3'd1: clkEn      <= 1'b0;
        3'd2: vppEn      <= 1'b0;
        3'd3: ioEn       <= 1'b0;
        3'd4: vccEn      <= 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cardSeen <= 1'b0;
      alarm    <= 1'b1;
    end else begin
      cardSeen <= cardPresent;
      alarm    <= hostFault || !supplyReady;
    end
  end

endmodule

// File: rtl/card_seq_top.sv
module card_seq_top
  import card_seq_pkg::*;
#(
  parameter int CYC_PER_US = 50,
  parameter int SHORT_US   = 32,
  parameter int LONG_US    = 64,
  parameter int DEACT_US   = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startN,
  input  logic       cardPresent,
  input  logic       ioHostHigh,
  input  logic       dirWrite,
  input  logic       mainFault,
  input  logic       hostFault,
  input  logic       supplyReady,
  output logic       vccEn,
  output logic       ioEn,
  output logic       vppEn,
  output logic       clkEn,
  output logic       rstRelease,
  output logic       ioRdEn,
  output logic       ioWrEn,
  output logic       cardSeen,
  output logic       alarm,
  output logic [2:0] stateCode
);

  localparam int SHORT_CYC = SHORT_US * CYC_PER_US;
  localparam int LONG_CYC  = LONG_US * CYC_PER_US;
  localparam int DEACT_CYC = DEACT_US * CYC_PER_US;

  seqState_e  state;
  seqStrobe_t strb;
  logic       timerDone;
  logic       anyFault;

  assign anyFault = mainFault || hostFault;

  card_seq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startN      (startN),
    .cardPresent (cardPresent),
    .ioHostHigh  (ioHostHigh),
    .dirWrite    (dirWrite),
    .anyFault    (anyFault),
    .supplyReady (supplyReady),
    .timerDone   (timerDone),
    .state       (state),
    .strb        (strb)
  );

  card_seq_dp #(
    .SHORT_CYC (SHORT_CYC),
    .LONG_CYC  (LONG_CYC),
    .DEACT_CYC (DEACT_CYC)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .cardPresent (cardPresent),
    .hostFault   (hostFault),
    .supplyReady (supplyReady),
    .timerDone   (timerDone),
    .vccEn       (vccEn),
    .ioEn        (ioEn),
    .vppEn       (vppEn),
    .clkEn       (clkEn),
    .rstRelease  (rstRelease),
    .cardSeen    (cardSeen),
    .alarm       (alarm)
  );

  assign stateCode = state;
  assign ioRdEn    = (state == ST_READ);
  assign ioWrEn    = (state == ST_WRITE);

endmodule

// File: rtl/card_seq_chk.sv
module card_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       startN,
  input logic       cardPresent,
  input logic       ioHostHigh,
  input logic       mainFault,
  input logic       hostFault,
  input logic       supplyReady,
  input logic       vccEn,
  input logic       ioEn,
  input logic       vppEn,
  input logic       clkEn,
  input logic       rstRelease,
  input logic       ioRdEn,
  input logic       ioWrEn,
  input logic       alarm,
  input logic [2:0] stateCode
);

  logic inRun;
  assign inRun = (stateCode == 3'd1) || (stateCode == 3'd2) || (stateCode == 3'd3);

  AST_IDLE_ALL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd0) |-> (!vccEn && !ioEn && !vppEn && !clkEn && !rstRelease && !ioRdEn && !ioWrEn)); // R1

  AST_START_POWERS_VCC: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd0 && !startN && ioHostHigh && cardPresent && supplyReady && !mainFault && !hostFault)
    |=> (vccEn && stateCode == 3'd1)); // R2

  AST_CONTACT_CHAIN: assert property (@(posedge clk) disable iff (!rstN)
    (!ioEn || vccEn) && (!vppEn || ioEn) && (!clkEn || vppEn) && (!rstRelease || clkEn)); // R3

  AST_SESSION_POWERED: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd2 || stateCode == 3'd3) |-> (rstRelease && vccEn)); // R4

  AST_STOP_DEACT: assert property (@(posedge clk) disable iff (!rstN)
    ((stateCode == 3'd2 || stateCode == 3'd3) && startN) |=> (stateCode == 3'd4 && !rstRelease)); // R5

  AST_CARD_GONE: assert property (@(posedge clk) disable iff (!rstN)
    (inRun && !cardPresent) |=> (stateCode == 3'd4)); // R6

  AST_FAULT_DEACT: assert property (@(posedge clk) disable iff (!rstN)
    (inRun && (mainFault || hostFault)) |=> (stateCode == 3'd4 && !rstRelease)); // R7

  AST_FAULT_NO_SUPPLY: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd5) |-> !vccEn); // R7

  AST_ALARM_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    (hostFault || !supplyReady) |=> alarm); // R8

endmodule

bind card_seq_top card_seq_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .startN      (startN),
  .cardPresent (cardPresent),
  .ioHostHigh  (ioHostHigh),
  .mainFault   (mainFault),
  .hostFault   (hostFault),
  .supplyReady (supplyReady),
  .vccEn       (vccEn),
  .ioEn        (ioEn),
  .vppEn       (vppEn),
  .clkEn       (clkEn),
  .rstRelease  (rstRelease),
  .ioRdEn      (ioRdEn),
  .ioWrEn      (ioWrEn),
  .alarm       (alarm),
  .stateCode   (stateCode)
);

// File: tb/test_card_seq_top.sv
module test_card_seq_top;

  logic clk = 1'b0;
  logic rstN;
  logic startN, cardPresent, ioHostHigh, dirWrite, mainFault, hostFault, supplyReady;
  logic vccEn, ioEn, vppEn, clkEn, rstRelease, ioRdEn, ioWrEn, cardSeen, alarm;
  logic [2:0] stateCode;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  // 1 cycle per us: short 32, long 64, deactivation step 8 cycles
  card_seq_top #(.CYC_PER_US(1)) i_card_seq_top (
    .clk(clk), .rstN(rstN), .startN(startN), .cardPresent(cardPresent),
    .ioHostHigh(ioHostHigh), .dirWrite(dirWrite), .mainFault(mainFault),
    .hostFault(hostFault), .supplyReady(supplyReady), .vccEn(vccEn), .ioEn(ioEn),
    .vppEn(vppEn), .clkEn(clkEn), .rstRelease(rstRelease), .ioRdEn(ioRdEn),
    .ioWrEn(ioWrEn), .cardSeen(cardSeen), .alarm(alarm), .stateCode(stateCode)
  );

  // inputs {startN,card,ioHigh,dirWrite,mainFault,hostFault,ready}, edges,
  // expected {vcc,io,vpp,clk,rstRel,rdEn,wrEn,state[2:0]}
  localparam int NV = 33;
  localparam logic [24:0] VEC [NV] = '{
    {7'b0110001, 8'd1,  10'b10000_00_001},  // R2 start accepted
    {7'b0110001, 8'd31, 10'b10000_00_001},  // R3 io not yet
    {7'b0110001, 8'd1,  10'b11000_00_001},  // R3 io at 32
    {7'b0110001, 8'd32, 10'b11100_00_001},  // R3 vpp at 64
    {7'b0110001, 8'd64, 10'b11100_00_001},  // R3 no-change step
    {7'b0110001, 8'd64, 10'b11110_00_001},  // R3 clk at 192
    {7'b0110001, 8'd63, 10'b11110_00_001},  // R3 reset held
    {7'b0110001, 8'd1,  10'b11111_10_010},  // R4 released, read
    {7'b0111001, 8'd1,  10'b11111_01_011},  // R4 write
    {7'b0110001, 8'd1,  10'b11111_10_010},  // R4 back to read
    {7'b1110001, 8'd1,  10'b11110_00_100},  // R5 stop, reset first
    {7'b1110001, 8'd8,  10'b11100_00_100},  // R5 clk off
    {7'b1110001, 8'd8,  10'b11000_00_100},  // R5 vpp off
    {7'b1110001, 8'd8,  10'b10000_00_100},  // R5 io off
    {7'b1110001, 8'd8,  10'b00000_00_100},  // R5 vcc off
    {7'b1110001, 8'd7,  10'b00000_00_100},  // R5 still deactivating
    {7'b1110001, 8'd1,  10'b00000_00_000},  // R5 idle
    {7'b0110001, 8'd1,  10'b10000_00_001},  // R6 new activation
    {7'b0110001, 8'd32, 10'b11000_00_001},  // R6 io up
    {7'b0010001, 8'd1,  10'b11000_00_100},  // R6 card removed
    {7'b0110001, 8'd20, 10'b11000_00_100},  // R6 start ignored mid-deact
    {7'b0110001, 8'd20, 10'b00000_00_000},  // R6 idle reached
    {7'b0110001, 8'd1,  10'b10000_00_001},  // R6 start taken again
    {7'b0110101, 8'd1,  10'b10000_00_100},  // R7 main fault aborts
    {7'b0110101, 8'd40, 10'b00000_00_101},  // R7 ends in fault
    {7'b0110101, 8'd5,  10'b00000_00_101},  // R7 stays in fault
    {7'b0110001, 8'd1,  10'b00000_00_000},  // R7 fault cleared
    {7'b1110001, 8'd1,  10'b00000_00_000},  // R7 quiet idle
    {7'b0100001, 8'd3,  10'b00000_00_000},  // R2 host io low blocks
    {7'b0010001, 8'd3,  10'b00000_00_000},  // R2 no card blocks
    {7'b0110000, 8'd3,  10'b00000_00_000},  // R2 not ready blocks
    {7'b1110010, 8'd1,  10'b00000_00_101},  // R7 fault in idle
    {7'b1110001, 8'd1,  10'b00000_00_000}   // R7 recovery
  };

  function automatic string reqName(input int i);
    if (i == 0) return "R2";
    else if (i <= 6) return "R3";
    else if (i <= 9) return "R4";
    else if (i <= 16) return "R5";
    else if (i <= 22) return "R6";
    else if (i <= 27) return "R7";
    else if (i <= 30) return "R2";
    else return "R7";
  endfunction

  function automatic logic [9:0] obs();
    return {vccEn, ioEn, vppEn, clkEn, rstRelease, ioRdEn, ioWrEn, stateCode};
  endfunction

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 5000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finishRun();
  end

  initial begin
    rstN = 1'b0;
    startN = 1'b1; cardPresent = 1'b1; ioHostHigh = 1'b1; dirWrite = 1'b0;
    mainFault = 1'b0; hostFault = 1'b0; supplyReady = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset values
    chk("R1", obs(), 10'b00000_00_000);
    chk("R1", {8'd0, alarm, cardSeen}, 10'b00000000_10);
    rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1", obs(), 10'b00000_00_000);
    chk("R8", {8'd0, alarm, cardSeen}, 10'b00000000_01);

    for (int i = 0; i < NV; i++) begin
      {startN, cardPresent, ioHostHigh, dirWrite, mainFault, hostFault, supplyReady} = VEC[i][24:18];
      repeat (int'(VEC[i][17:10])) @(posedge clk);
      @(negedge clk);
      chk(reqName(i), obs(), VEC[i][9:0]);
    end

    // R8 alarm and card status, one edge late
    supplyReady = 1'b0; cardPresent = 1'b0;
    chk("R8", {8'd0, alarm, cardSeen}, 10'b00000000_01);
    @(posedge clk); @(negedge clk);
    chk("R8", {8'd0, alarm, cardSeen}, 10'b00000000_10);
    supplyReady = 1'b1; hostFault = 1'b1; cardPresent = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R8", {8'd0, alarm, cardSeen}, 10'b00000000_11);
    hostFault = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R8", {8'd0, alarm, cardSeen}, 10'b00000000_01);
    finishRun();
  end

endmodule